// File: doc/BRIEF.md
# Link Mode Mismatch Detector

This block confirms that the speed and duplex the MAC has settled on match the result of PHY autonegotiation. A single-cycle `start` pulse launches one check. The check goes ahead only when the MAC reports link up and the PHY basic-status register also shows link up. The block then reads the PHY's local advertisement and link-partner ability words and ANDs them together. From the common abilities it picks the best shared mode in a fixed order and compares that mode with the two-bit mode the MAC reports.

If the two modes differ, the block reads PHY control register 0. It writes the value back with the restart-autonegotiation bit set. It then holds off for a settle period, given as a cycle count, and accepts no new check until that period ends. All PHY register traffic goes through a plain request/acknowledge port. The serial management protocol sits outside this block. The outcome of each check is reported on status flags, along with the resolved mode.

Top module: `link_mode_checker`

## Requirements
- R1: After reset, `busy`, `done`, `mismatch`, `restarted`, `res_valid`, `res_mode` and `reg_req` are all 0, and `reg_req` is never raised while `busy` is 0.
- R2: A start pulse while `mac_link` is 0 makes no PHY access. It sets `done`, leaves `mismatch` and `restarted` at 0, and leaves `res_valid` at 0.
- R3: When `mac_link` is 1, the first access reads PHY register 1. If bit 2 of the returned value (PHY link) is 0, the check ends with `done` and makes no further access.
- R4: When the PHY link is up, the block reads register 4 (local advertisement) and then register 5 (partner ability). Only the bitwise AND of the two words is used for resolution.
- R5: The ability bits are: bit 8 for 100 Mb/s full duplex, bit 7 for 100 half, bit 6 for 10 full, and bit 5 for 10 half. The highest-ranked common bit wins in that order. It is encoded on `res_mode` as 3, 1, 2 or 0, where bit 0 means 100 Mb/s and bit 1 means full duplex. `res_valid` is then 1.
- R6: If none of the four ability bits is common, `res_valid` stays 0 and the check ends with `done`, with no write to the PHY.
- R7: If the resolved mode equals `mac_mode`, the check ends with `done`, `mismatch` at 0, and no write to the PHY.
- R8: If the resolved mode differs from `mac_mode`, the block sets `mismatch`, reads register 0, and writes register 0 with the value read ORed with 0x0200 (bit 9). This is the only write the block ever makes.
- R9: After the restart write is acknowledged, `busy` stays high. `done` and `restarted` rise exactly `SETTLE_CYC` clock cycles after that acknowledge.
- R10: A start pulse that arrives while `busy` is 1, including during the settle period, is ignored and causes no PHY access.
- R11: While `reg_req` is 1 and `reg_ack` is 0, `reg_req`, `reg_wr`, `reg_addr` and `reg_wdata` hold their values into the next cycle.
- R12: Accepting a new check clears `done`, `mismatch`, `restarted` and `res_valid` in the cycle after the start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| start | input | 1 | One-cycle pulse that launches a check when idle |
| mac_link | input | 1 | MAC port link status |
| mac_mode | input | 2 | MAC resolved mode: bit 0 = 100 Mb/s, bit 1 = full duplex |
| reg_req | output | 1 | PHY register access request, held until acknowledged |
| reg_wr | output | 1 | 1 = write access, 0 = read access |
| reg_addr | output | 5 | PHY register number |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | One-cycle access acknowledge |
| reg_rdata | input | 16 | Read data, valid with `reg_ack` |
| busy | output | 1 | A check or the settle period is in progress |
| done | output | 1 | The last check has finished |
| mismatch | output | 1 | The last check found a disagreement |
| restarted | output | 1 | The last check issued a restart and completed its settle period |
| res_valid | output | 1 | A common mode was found in the last check |
| res_mode | output | 2 | The resolved common mode |

## Verification
The resolver is exercised with several ability pairs whose common sets are led by each of the four modes. This separates a wrong priority order from a wrong encoding, for example 10 full duplex against 100 half duplex. One pair shares only a lower bit while higher bits are set on just one side, which shows whether the AND is really taken. A pair with no common bit confirms that no action is taken. Each good resolution is run against both a matching and a differing MAC mode. Control words with and without bit 9 already set check that the read-modify-write keeps the other bits. Acknowledge latencies of one to three cycles, a start pulse during the settle time, and checks with the MAC or PHY link down exercise the sequencing paths.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

  localparam int unsigned REG_AW = 5;
  localparam int unsigned REG_DW = 16;

  // PHY register numbers used by the check
  localparam logic [REG_AW-1:0] PHY_CTRL_REG = 5'd0;
  localparam logic [REG_AW-1:0] PHY_STAT_REG = 5'd1;
  localparam logic [REG_AW-1:0] PHY_ADV_REG  = 5'd4;
  localparam logic [REG_AW-1:0] PHY_PART_REG = 5'd5;

  // Bit positions
  localparam int unsigned STAT_LINK_BIT = 2;
  localparam int unsigned CTRL_RENEG_BIT = 9;
  localparam int unsigned ABIL_LO_BIT = 5;   // 10 half duplex
  localparam int unsigned ABIL_N = 4;        // bits 5..8

  // Resolved mode encoding: bit0 = 100 Mb/s, bit1 = full duplex
  localparam logic [1:0] MODE_100F = 2'd3;
  localparam logic [1:0] MODE_100H = 2'd1;
  localparam logic [1:0] MODE_10F  = 2'd2;
  localparam logic [1:0] MODE_10H  = 2'd0;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_ST  = 3'd1,
    ST_RD_ADV = 3'd2,
    ST_RD_LP  = 3'd3,
    ST_EVAL   = 3'd4,
    ST_RD_CTL = 3'd5,
    ST_WR_CTL = 3'd6,
    ST_SETTLE = 3'd7
  } chk_state_e;

endpackage

// File: rtl/lmd_resolve.sv
module lmd_resolve
  import lmd_pkg::*;
(
  input  logic [ABIL_N-1:0] common,   // index 0 = 10H, 1 = 10F, 2 = 100H, 3 = 100F
  output logic              found,
  output logic [1:0]        mode
);

  // Rank table: position 0 is the most preferred ability
  localparam int unsigned RANK_IDX [ABIL_N] = '{3, 2, 1, 0};
  localparam logic [1:0]  RANK_MODE[ABIL_N] = '{MODE_100F, MODE_100H, MODE_10F, MODE_10H};

  always_comb begin
    found = 1'b0;
    mode  = MODE_10H;
    for (int r = ABIL_N - 1; r >= 0; r--) begin
      if (common[RANK_IDX[r]]) begin
        found = 1'b1;
        mode  = RANK_MODE[r];
      end
    end
  end

endmodule

// File: rtl/lmd_settle_timer.sv
module lmd_settle_timer #(
  parameter int unsigned SETTLE_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_en = load | (run & ~expired);
    cnt_d  = load ? LOAD_VAL : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lmd_regport.sv
module lmd_regport
  import lmd_pkg::*;
(
  input  chk_state_e        state,
  input  logic [REG_DW-1:0] ctrl_val,
  output logic              req,
  output logic              wr,
  output logic [REG_AW-1:0] addr,
  output logic [REG_DW-1:0] wdata
);

  localparam logic [REG_DW-1:0] RENEG_MASK = REG_DW'(1) << CTRL_RENEG_BIT;

  always_comb begin
    req   = 1'b0;
    wr    = 1'b0;
    addr  = '0;
    wdata = '0;
    unique case (state)
      ST_RD_ST:  begin req = 1'b1; addr = PHY_STAT_REG; end
      ST_RD_ADV: begin req = 1'b1; addr = PHY_ADV_REG;  end
      ST_RD_LP:  begin req = 1'b1; addr = PHY_PART_REG; end
      ST_RD_CTL: begin req = 1'b1; addr = PHY_CTRL_REG; end
      ST_WR_CTL: begin
        req   = 1'b1;
        wr    = 1'b1;
        addr  = PHY_CTRL_REG;
        wdata = ctrl_val | RENEG_MASK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/link_mode_checker.sv
module link_mode_checker
  import lmd_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mac_link,
  input  logic [1:0]        mac_mode,
  output logic              reg_req,
  output logic              reg_wr,
  output logic [REG_AW-1:0] reg_addr,
  output logic [REG_DW-1:0] reg_wdata,
  input  logic              reg_ack,
  input  logic [REG_DW-1:0] reg_rdata,
  output logic              busy,
  output logic              done,
  output logic              mismatch,
  output logic              restarted,
  output logic              res_valid,
  output logic [1:0]        res_mode
);

  chk_state_e state_q, state_d;

  logic [ABIL_N-1:0] adv_q, common_q;
  logic [REG_DW-1:0] ctrl_q;
  logic              adv_en, common_en, ctrl_en;

  logic done_q, done_d, mis_q, mis_d, rst_q, rst_d, rv_q, rv_d;
  logic [1:0] rm_q, rm_d;
  logic       flag_en;

  logic       accept, rs_found, tmr_load, tmr_exp;
  logic [1:0] rs_mode;

  assign accept = (state_q == ST_IDLE) & start;

  lmd_resolve u_resolve (
    .common (common_q),
    .found  (rs_found),
    .mode   (rs_mode)
  );

  assign tmr_load = (state_q == ST_WR_CTL) & reg_ack;

  lmd_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .run     (state_q == ST_SETTLE),
    .expired (tmr_exp)
  );

  lmd_regport u_port (
    .state    (state_q),
    .ctrl_val (ctrl_q),
    .req      (reg_req),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start && mac_link) state_d = ST_RD_ST;
      ST_RD_ST:  if (reg_ack) state_d = reg_rdata[STAT_LINK_BIT] ? ST_RD_ADV : ST_IDLE;
      ST_RD_ADV: if (reg_ack) state_d = ST_RD_LP;
      ST_RD_LP:  if (reg_ack) state_d = ST_EVAL;
      ST_EVAL: begin
        if (!rs_found || rs_mode == mac_mode) state_d = ST_IDLE;
        else                                   state_d = ST_RD_CTL;
      end
      ST_RD_CTL: if (reg_ack) state_d = ST_WR_CTL;
      ST_WR_CTL: if (reg_ack) state_d = ST_SETTLE;
      ST_SETTLE: if (tmr_exp) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Capture enables for the ability words and control value
  always_comb begin
    adv_en    = (state_q == ST_RD_ADV) & reg_ack;
    common_en = (state_q == ST_RD_LP)  & reg_ack;
    ctrl_en   = (state_q == ST_RD_CTL) & reg_ack;
  end

  // Status flag next values
  always_comb begin
    done_d  = done_q;
    mis_d   = mis_q;
    rst_d   = rst_q;
    rv_d    = rv_q;
    rm_d    = rm_q;
    flag_en = 1'b0;
    if (accept) begin
      flag_en = 1'b1;
      done_d  = ~mac_link;
      mis_d   = 1'b0;
      rst_d   = 1'b0;
      rv_d    = 1'b0;
      rm_d    = 2'd0;
    end else begin
      unique case (state_q)
        ST_RD_ST: if (reg_ack && !reg_rdata[STAT_LINK_BIT]) begin
          flag_en = 1'b1;
          done_d  = 1'b1;
        end
        ST_EVAL: begin
          flag_en = 1'b1;
          rv_d    = rs_found;
          rm_d    = rs_found ? rs_mode : 2'd0;
          if (!rs_found || rs_mode == mac_mode) done_d = 1'b1;
          else                                   mis_d  = 1'b1;
        end
        ST_SETTLE: if (tmr_exp) begin
          flag_en = 1'b1;
          done_d  = 1'b1;
          rst_d   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_q <= '0;
    end else if (adv_en) begin
      adv_q <= reg_rdata[ABIL_LO_BIT +: ABIL_N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      common_q <= '0;
    end else if (common_en) begin
      common_q <= adv_q & reg_rdata[ABIL_LO_BIT +: ABIL_N];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= reg_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      mis_q  <= 1'b0;
      rst_q  <= 1'b0;
      rv_q   <= 1'b0;
      rm_q   <= 2'd0;
    end else if (flag_en) begin
      done_q <= done_d;
      mis_q  <= mis_d;
      rst_q  <= rst_d;
      rv_q   <= rv_d;
      rm_q   <= rm_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign mismatch  = mis_q;
  assign restarted = rst_q;
  assign res_valid = rv_q;
  assign res_mode  = rm_q;

endmodule

// File: rtl/lmd_checker.sv
module lmd_checker
  import lmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mismatch,
  input logic              restarted,
  input logic              res_valid,
  input logic              reg_req,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic              reg_ack
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_wr) && $stable(reg_addr) && $stable(reg_wdata)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_req);

  // R8
  write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_wr) |-> (reg_addr == PHY_CTRL_REG && reg_wdata[CTRL_RENEG_BIT] && mismatch));

  // R9
  restart_implies_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restarted |-> (mismatch && done && !busy));

  // R6
  mis_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> res_valid);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !reg_req);

endmodule

bind link_mode_checker lmd_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mismatch  (mismatch),
  .restarted (restarted),
  .res_valid (res_valid),
  .reg_req   (reg_req),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_ack   (reg_ack)
);

// File: tb/link_mode_checker_tb_top.sv
module link_mode_checker_tb_top;

  localparam int unsigned SETTLE = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        mac_link;
  logic [1:0]  mac_mode;
  logic        reg_req, reg_wr;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_ack;
  logic [15:0] reg_rdata;
  logic        busy, done, mismatch, restarted, res_valid;
  logic [1:0]  res_mode;

  always #5 clk = ~clk;

  link_mode_checker #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk, .rst_n, .start, .mac_link, .mac_mode,
    .reg_req, .reg_wr, .reg_addr, .reg_wdata, .reg_ack, .reg_rdata,
    .busy, .done, .mismatch, .restarted, .res_valid, .res_mode
  );

  int    nvec = 0;
  int    nmis = 0;
  int    lat = 1;
  int    wcnt = 0;
  bit    in_run = 0;
  time   wr_time = 0;
  logic [15:0] regs [32];
  logic [21:0] expq [$];   // {wr, addr, data}

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nmis++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // PHY register responder with programmable ack latency
  always @(negedge clk) begin
    if (reg_ack) begin
      reg_ack = 1'b0;
    end else if (reg_req) begin
      wcnt++;
      if (wcnt >= lat) begin
        wcnt = 0;
        if (expq.size() == 0) begin
          chk(1'b0, "R10", "unexpected PHY access addr", reg_addr, 0);
        end else begin
          logic [21:0] e;
          e = expq.pop_front();
          chk(reg_wr == e[21] && reg_addr == e[20:16], "R4", "access order {wr,addr}",
              {reg_wr, reg_addr}, e[21:16]);
          if (e[21]) chk(reg_wdata == e[15:0], "R8", "restart write data", reg_wdata, e[15:0]);
        end
        reg_rdata = regs[reg_addr];
        if (reg_wr) begin
          regs[reg_addr] = reg_wdata;
          wr_time = $time;
        end
        reg_ack = 1'b1;
      end
    end
    if (!in_run && rst_n)
      chk(!busy && !reg_req, "R1", "idle busy/req", {busy, reg_req}, 0);
  end

  // One check with behaviourally computed expectations
  task automatic run_check(input bit ml, input logic [1:0] mm, input logic [15:0] stat,
                           input logic [15:0] adv, input logic [15:0] lp,
                           input logic [15:0] ctl, input int l, input bit mid_start);
    bit exp_valid, exp_mis, exp_rst, pulsed;
    logic [1:0] exp_mode;
    logic [15:0] com;
    int n;
    time done_t;
    lat = l; wcnt = 0; wr_time = 0; pulsed = 0;
    regs[1] = stat; regs[4] = adv; regs[5] = lp; regs[0] = ctl;
    exp_valid = 0; exp_mis = 0; exp_rst = 0; exp_mode = 0;
    if (ml) begin
      expq.push_back({1'b0, 5'd1, 16'h0});
      if (stat[2]) begin
        expq.push_back({1'b0, 5'd4, 16'h0});
        expq.push_back({1'b0, 5'd5, 16'h0});
        com = adv & lp;
        exp_valid = 1;
        if (com[8])      exp_mode = 2'd3;
        else if (com[7]) exp_mode = 2'd1;
        else if (com[6]) exp_mode = 2'd2;
        else if (com[5]) exp_mode = 2'd0;
        else             exp_valid = 0;
        if (exp_valid && exp_mode != mm) begin
          exp_mis = 1; exp_rst = 1;
          expq.push_back({1'b0, 5'd0, 16'h0});
          expq.push_back({1'b1, 5'd0, ctl | 16'h0200});
        end
      end
    end
    @(negedge clk);
    in_run = 1; mac_link = ml; mac_mode = mm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (ml) begin
      // R12: flags cleared on acceptance
      chk(busy && !done && !mismatch && !restarted && !res_valid, "R12",
          "flags after accept {busy,done,mis,rst,rv}",
          {busy, done, mismatch, restarted, res_valid}, 5'b10000);
    end
    n = 0; done_t = 0;
    while (!(done && !busy) && n < 3000) begin
      @(negedge clk);
      n++;
      if (mid_start && wr_time != 0 && !pulsed && busy && $time > wr_time + 20) begin
        start = 1'b1; pulsed = 1;          // R10: start during settle
        @(negedge clk);
        start = 1'b0;
        n++;
      end
    end
    done_t = $time;
    if (n >= 3000) chk(1'b0, "R9", "check never finished", n, 0);
    chk(expq.size() == 0, "R3", "accesses left unmade", expq.size(), 0);
    chk(mismatch == exp_mis, "R7", "mismatch flag", mismatch, exp_mis);
    chk(restarted == exp_rst, "R9", "restarted flag", restarted, exp_rst);
    chk(res_valid == exp_valid, "R6", "res_valid", res_valid, exp_valid);
    if (exp_valid) chk(res_mode == exp_mode, "R5", "resolved mode", res_mode, exp_mode);
    if (!ml) chk(done && !res_valid, "R2", "mac link down outcome", {done, res_valid}, 2'b10);
    if (exp_rst) begin
      chk((done_t - wr_time) / 10 == SETTLE + 1, "R9", "settle cycles after write ack",
          (done_t - wr_time) / 10 - 1, SETTLE);
      chk(regs[0] == (ctl | 16'h0200), "R8", "PHY control after restart", regs[0], ctl | 16'h0200);
    end
    // quiet period: any stray request is flagged by the responder
    repeat (4) @(negedge clk);
    expq.delete();
    in_run = 0;
  endtask

  initial begin
    #2000000;
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mac_link = 1'b0; mac_mode = 2'd0;
    reg_ack = 1'b0; reg_rdata = 16'h0;
    for (int i = 0; i < 32; i++) regs[i] = 16'h0;
    in_run = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk({busy, done, mismatch, restarted, res_valid, res_mode, reg_req} == 8'h00, "R1",
        "reset state", {busy, done, mismatch, restarted, res_valid, res_mode, reg_req}, 0);
    in_run = 0;

    run_check(1'b0, 2'd3, 16'h782D, 16'h01E1, 16'h01E1, 16'h1000, 1, 0); // R2
    run_check(1'b1, 2'd3, 16'h7809, 16'h01E1, 16'h01E1, 16'h1000, 2, 0); // R3 PHY link down
    run_check(1'b1, 2'd3, 16'h782D, 16'h01E1, 16'h01E1, 16'h1000, 2, 0); // R7 100F match
    run_check(1'b1, 2'd1, 16'h782D, 16'h01E1, 16'h01E1, 16'h1000, 1, 1); // R8 R10 mismatch
    run_check(1'b1, 2'd1, 16'h782D, 16'h01E1, 16'h00A1, 16'h1000, 3, 0); // R12 R5 100H match
    run_check(1'b1, 2'd0, 16'h782D, 16'h0061, 16'h01C1, 16'h3100, 3, 0); // R5 10F vs MAC 10H
    run_check(1'b1, 2'd0, 16'h782D, 16'h0021, 16'h01E1, 16'h1000, 1, 0); // R5 10H match
    run_check(1'b1, 2'd2, 16'h782D, 16'h0181, 16'h0061, 16'h1000, 2, 0); // R6 none common
    run_check(1'b1, 2'd2, 16'h782D, 16'h01E1, 16'h0141, 16'h0200, 1, 1); // R4 AND, bit9 preset

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

endmodule